// File: doc/BRIEF.md
# Receive Nibble Preamble Presentation Control

This block sits on the receive side of a media-independent interface. Its input is the decoded nibble stream from the line decoder: a carrier/valid qualifier, the nibble, and a strobe that marks the start-of-frame delimiter nibble. It decides what the MAC sees on `rxd` and `rx_dv` while a frame's preamble is arriving.

When preamble presentation is selected, every preamble nibble is shown as `0x5` with `rx_dv` high. This path carries one extra nibble of pipeline delay. When presentation is off, `rxd` stays at zero and `rx_dv` stays low until the delimiter arrives. The delimiter and all data after it are forwarded unchanged in both modes. In serial 10 Mb/s mode the preamble is always forwarded, one bit per cycle on `rxd[0]`, whatever the presentation setting.

The input is a valid-only stream. `in_valid` is its valid signal, and there is no ready, because the receive path cannot be stalled. The output follows the same rule: `rx_dv` is its valid signal, and the MAC must take every nibble in the cycle it is presented. Frames are separated by at least `EXTRA_STAGES` idle cycles (carrier low).

Top module: `rx_preamble_ctrl`

## Requirements
- R1: While `rst_n` is low, `rxd` is 0 and `rx_dv` is 0.
- R2: In presentation mode (`cfg_show_pre`=1, `cfg_serial`=0), each nibble that arrives before the delimiter appears two cycles later as `rxd`=0x5 with `rx_dv`=1, whatever the input nibble value.
- R3: In suppression mode (`cfg_show_pre`=0, `cfg_serial`=0), each nibble that arrives before the delimiter produces `rxd`=0 and `rx_dv`=0 one cycle later.
- R4: The delimiter nibble (the one with `in_sfd`=1) and every later nibble of the same carrier burst appear unchanged on `rxd` with `rx_dv`=1. The delay is two cycles in presentation mode and one cycle in suppression mode.
- R5: `rx_dv` rises with the first nibble of the burst in presentation mode, and with the delimiter nibble in suppression mode.
- R6: In serial mode (`cfg_serial`=1), every valid input bit `in_data[0]` appears one cycle later on `rxd[0]`, with `rxd[3:1]`=0 and `rx_dv`=1. This includes the preamble, whatever `cfg_show_pre` is.
- R7: A cycle with `in_valid`=0 produces `rxd`=0 and `rx_dv`=0 once its delay has elapsed. The next burst starts with no delimiter seen.
- R8: The mode is taken from `cfg_show_pre` and `cfg_serial` only on the first nibble of a burst (`in_valid` rising). Changes to them during a burst have no effect until the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_show_pre | input | 1 | 1 = present preamble as 0x5 nibbles |
| cfg_serial | input | 1 | 1 = serial 10 Mb/s mode on rxd[0] |
| in_valid | input | 1 | Carrier / nibble valid from the decoder |
| in_data | input | 4 | Decoded receive nibble |
| in_sfd | input | 1 | Marks the start-of-frame delimiter nibble |
| rxd | output | 4 | Receive data to the MAC |
| rx_dv | output | 1 | Receive data valid to the MAC |

## Verification
A nibble accepted at a clock edge appears on the outputs after one register in suppression and serial modes, and after two registers in presentation mode. The bench therefore writes each nibble's expected output into a per-cycle table, either one slot or two slots ahead of the cycle in which it drives that nibble. The outputs are compared against the table on the falling edge, before the next inputs are driven. Slots that no nibble fills are expected to be idle zeros. This catches a frame tail that leaks out too late or too early.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  parameter int NIB_W = 4;
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5;

  typedef enum logic [1:0] {
    MODE_SUPPRESS = 2'd0,
    MODE_PRESENT  = 2'd1,
    MODE_SERIAL   = 2'd2
  } rxp_mode_t;

  typedef struct packed {
    logic             dv;
    logic             long_path;
    logic [NIB_W-1:0] d;
  } rxp_ent_t;
endpackage

// File: rtl/rxp_frame_track.sv
module rxp_frame_track
  import rxp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_show_pre,
  input  logic      cfg_serial,
  input  logic      in_valid,
  input  logic      in_sfd,
  output rxp_mode_t cur_mode,
  output logic      seen_eff,
  output rxp_mode_t mode_q,
  output logic      in_frame_q
);
  logic      seen_q;
  logic      first;
  rxp_mode_t cfg_mode;

  always_comb begin
    first    = in_valid && !in_frame_q;
    cfg_mode = cfg_serial ? MODE_SERIAL : (cfg_show_pre ? MODE_PRESENT : MODE_SUPPRESS);
    cur_mode = first ? cfg_mode : mode_q;
    seen_eff = first ? 1'b0 : seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      seen_q     <= 1'b0;
      mode_q     <= MODE_SUPPRESS;
    end else begin
      in_frame_q <= in_valid;
      seen_q     <= in_valid && (seen_eff || in_sfd);
      if (first) mode_q <= cfg_mode;
    end
  end
endmodule

// File: rtl/rxp_nibble_fmt.sv
module rxp_nibble_fmt
  import rxp_pkg::*;
(
  input  rxp_mode_t        cur_mode,
  input  logic             seen_eff,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_data,
  input  logic             in_sfd,
  output rxp_ent_t         ent
);
  always_comb begin
    ent = '0;
    if (in_valid) begin
      ent.long_path = (cur_mode == MODE_PRESENT);
      if (cur_mode == MODE_SERIAL) begin
        ent.dv = 1'b1;
        ent.d  = {{(NIB_W-1){1'b0}}, in_data[0]};
      end else if (in_sfd || seen_eff) begin
        ent.dv = 1'b1;
        ent.d  = in_data;
      end else if (cur_mode == MODE_PRESENT) begin
        ent.dv = 1'b1;
        ent.d  = PRE_NIB;
      end
    end
  end
endmodule

// File: rtl/rxp_delay.sv
module rxp_delay
  import rxp_pkg::*;
#(
  parameter int EXTRA_STAGES = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  rxp_ent_t ent_in,
  output rxp_ent_t ent_out
);
  localparam int NSTG = EXTRA_STAGES + 1;

  rxp_ent_t stg [NSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTG; i++) stg[i] <= '0;
    end else begin
      stg[0] <= ent_in;
      for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
    end
  end

  generate
    if (EXTRA_STAGES == 0) begin : g_flat
      assign ent_out = stg[0];
    end else begin : g_sel
      logic any_long;
      always_comb begin
        any_long = 1'b0;
        for (int i = 0; i < NSTG; i++) any_long = any_long | stg[i].long_path;
        ent_out = any_long ? stg[NSTG-1] : stg[0];
      end
    end
  endgenerate
endmodule

// File: rtl/rx_preamble_ctrl.sv
module rx_preamble_ctrl
  import rxp_pkg::*;
#(
  parameter int EXTRA_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_show_pre,
  input  logic             cfg_serial,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_data,
  input  logic             in_sfd,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv
);
  rxp_mode_t cur_mode;
  rxp_mode_t mode_q;
  logic      seen_eff;
  logic      in_frame_q;
  rxp_ent_t  ent_fmt;
  rxp_ent_t  ent_out;

  rxp_frame_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_show_pre (cfg_show_pre),
    .cfg_serial   (cfg_serial),
    .in_valid     (in_valid),
    .in_sfd       (in_sfd),
    .cur_mode     (cur_mode),
    .seen_eff     (seen_eff),
    .mode_q       (mode_q),
    .in_frame_q   (in_frame_q)
  );

  rxp_nibble_fmt u_fmt (
    .cur_mode (cur_mode),
    .seen_eff (seen_eff),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sfd   (in_sfd),
    .ent      (ent_fmt)
  );

  rxp_delay #(.EXTRA_STAGES(EXTRA_STAGES)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent_in  (ent_fmt),
    .ent_out (ent_out)
  );

  assign rxd   = ent_out.d;
  assign rx_dv = ent_out.dv;
endmodule

// File: rtl/rxp_chk.sv
module rxp_chk
  import rxp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NIB_W-1:0] in_data,
  input logic             in_sfd,
  input logic [NIB_W-1:0] rxd,
  input logic             rx_dv,
  input rxp_mode_t        cur_mode,
  input rxp_mode_t        mode_q,
  input logic             seen_eff,
  input logic             in_frame_q
);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |-> (rxd == '0));

  a_r6_serial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_mode == MODE_SERIAL) |=>
      (rx_dv && rxd[NIB_W-1:1] == '0 && rxd[0] == $past(in_data[0])));

  a_r3_suppress_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_mode == MODE_SUPPRESS && !in_sfd && !seen_eff) |=> !rx_dv);

  a_r4_suppress_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_mode == MODE_SUPPRESS && (in_sfd || seen_eff)) |=>
      (rx_dv && rxd == $past(in_data)));

  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_frame_q) |=> $stable(mode_q));
endmodule

bind rx_preamble_ctrl rxp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_sfd     (in_sfd),
  .rxd        (rxd),
  .rx_dv      (rx_dv),
  .cur_mode   (cur_mode),
  .mode_q     (mode_q),
  .seen_eff   (seen_eff),
  .in_frame_q (in_frame_q)
);

// File: tb/rx_preamble_ctrl_tb.sv
module rx_preamble_ctrl_tb;
  localparam int NSLOT = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_show_pre = 1'b0;
  logic       cfg_serial = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_data = 4'h0;
  logic       in_sfd = 1'b0;
  logic [3:0] rxd;
  logic       rx_dv;

  logic       nxt_pe = 1'b0;
  logic       nxt_ser = 1'b0;
  int         nchk = 0;
  int         nfail = 0;
  int         cyc = 0;
  logic       exp_dv [NSLOT];
  logic [3:0] exp_d  [NSLOT];
  string      exp_tag [NSLOT];
  string      tag_ovr = "";
  logic       m_inframe = 1'b0;
  logic       m_seen = 1'b0;
  int         m_mode = 0;

  always #4 clk = ~clk;

  rx_preamble_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_show_pre (cfg_show_pre),
    .cfg_serial   (cfg_serial),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_sfd       (in_sfd),
    .rxd          (rxd),
    .rx_dv        (rx_dv)
  );

  task automatic put(input int slot, input logic dv, input logic [3:0] d, input string tg);
    exp_dv[slot]  = dv;
    exp_d[slot]   = d;
    exp_tag[slot] = (tag_ovr != "") ? tag_ovr : tg;
  endtask

  task automatic model(input logic v, input logic [3:0] d, input logic s);
    logic first;
    first = v && !m_inframe;
    if (first) begin
      m_mode = nxt_ser ? 2 : (nxt_pe ? 1 : 0);
      m_seen = 1'b0;
    end
    if (v) begin
      if (m_mode == 2) put(cyc + 1, 1'b1, {3'b000, d[0]}, "R6");
      else if (m_mode == 1) begin
        if (s || m_seen) put(cyc + 2, 1'b1, d, "R4");
        else put(cyc + 2, 1'b1, 4'h5, first ? "R5" : "R2");
      end else begin
        if (s || m_seen) put(cyc + 1, 1'b1, d, (s && !m_seen) ? "R5" : "R4");
        else put(cyc + 1, 1'b0, 4'h0, "R3");
      end
    end
    m_seen    = v && (m_seen || s);
    m_inframe = v;
  endtask

  task automatic tick(input logic v, input logic [3:0] d, input logic s);
    @(negedge clk);
    nchk++;
    if (rx_dv !== exp_dv[cyc] || rxd !== exp_d[cyc]) begin
      nfail++;
      $display("FAIL %s slot %0d: actual dv=%b rxd=%h expected dv=%b rxd=%h",
               exp_tag[cyc], cyc, rx_dv, rxd, exp_dv[cyc], exp_d[cyc]);
    end
    in_valid = v; in_data = d; in_sfd = s;
    cfg_show_pre = nxt_pe; cfg_serial = nxt_ser;
    if (rst_n) model(v, d, s);
    cyc++;
  endtask

  task automatic send_frame(input int pre, input int dl, input bit sfd_on, input bit flip);
    for (int i = 0; i < pre; i++) begin
      if (flip && i == 2) begin nxt_pe = !nxt_pe; nxt_ser = !nxt_ser; end
      tick(1'b1, 4'(i * 7 + 3), 1'b0);
    end
    if (sfd_on) tick(1'b1, 4'hD, 1'b1);
    for (int j = 0; j < dl; j++) tick(1'b1, 4'(j * 5 + pre + 1), 1'b0);
  endtask

  initial begin
    for (int k = 0; k < NSLOT; k++) begin
      exp_dv[k] = 1'b0; exp_d[k] = 4'h0; exp_tag[k] = (k < 5) ? "R1" : "R7";
    end
    for (int k = 0; k < 4; k++) tick(1'b0, 4'h0, 1'b0);
    rst_n = 1'b1;
    // R2 R3 R4 R5 R6 R7: sweep of mode, preamble length, data length, delimiter presence
    for (int ser = 0; ser < 2; ser++)
      for (int pe = 0; pe < 2; pe++)
        for (int pre = 0; pre < 4; pre++)
          for (int dl = 1; dl < 4; dl++)
            for (int sf = 0; sf < 2; sf++) begin
              nxt_ser = 1'(ser); nxt_pe = 1'(pe);
              send_frame(pre, dl, 1'(sf), 1'b0);
              for (int g = 0; g < 1 + (pre % 2); g++) tick(1'b0, 4'h0, 1'b0);
            end
    // R8: configuration flips inside a burst are ignored
    tag_ovr = "R8";
    for (int pe = 0; pe < 2; pe++)
      for (int ser = 0; ser < 2; ser++) begin
        nxt_pe = 1'(pe); nxt_ser = 1'(ser);
        send_frame(5, 3, 1'b1, 1'b1);
        tick(1'b0, 4'h0, 1'b0);
        tick(1'b0, 4'h0, 1'b0);
      end
    tag_ovr = "";
    for (int k = 0; k < 4; k++) tick(1'b0, 4'h0, 1'b0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL R7 watchdog: actual=still running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule